// File: doc/BRIEF.md
# Text Overlay for an RGB Video Stream

This block stamps a short line of text, such as a channel label, onto a 24-bit RGB pixel stream that carries horizontal sync, vertical sync and data-enable timing. The text is made of up to seven characters taken from a small built-in 8x8 font. Its position, size, colour, character codes and character count come from static configuration inputs.

The block counts active pixels and active lines from the data-enable and vertical-sync inputs. For each active pixel it decides whether that pixel lies on a set glyph bit of one of the drawn characters. Text pixels are replaced by a palette colour, and every other pixel passes through unchanged. The pixel data and all three timing signals leave the block two clock cycles after they enter, so the output stream stays aligned. Changing the configuration while a frame is in flight takes effect on the next pixel that enters the block.

Top module: `text_osd_overlay`

## Requirements
- R1: While `rst_n` is low, `out_rgb`, `out_hs`, `out_vs` and `out_de` are all zero.
- R2: Coordinates count active pixels. The column is the number of `in_de`-high pixels earlier in the same run of `in_de`. The row is the number of `in_de` falling edges since `in_vs` was last high. The top-left corner of the text sits at row 4*`pos_cfg[7:4]`+8 and column 4*`pos_cfg[3:0]`+20.
- R3: With n = `ctl_cfg[5:4]`, each glyph pixel covers an (n+1)x(n+1) block of screen pixels. Character slot k covers columns 8(n+1)k to 8(n+1)(k+1)-1 measured from the text origin. Code 00 is the smallest size and 11 is the largest.
- R4: A text pixel takes its colour from `ctl_cfg[3:0]`, with `out_rgb` = {R,G,B}. Codes 0 to 5 give ff0000, 00ff00, 0000ff, ffff00, ff00ff and 00ffff. Code c from 6 to 15 gives a grey with all three components equal to 16*(c-5).
- R5: When `osd_on` is 0, `out_rgb` equals `in_rgb` from two cycles earlier.
- R6: `out_rgb`, `out_hs`, `out_vs` and `out_de` are the corresponding inputs delayed by exactly two clock cycles, apart from the text substitution in `out_rgb`.
- R7: Only slots 0 to `char_cnt`-1 are drawn, with slot k held in `char_codes[4k+3:4k]` and slot 0 leftmost. A count of 0 draws nothing.
- R8: The font maps code 0 to 9 to the decimal digits, 10 to C, 11 to H, 12 to N, 13 to S, 14 to a dash and 15 to blank. Each glyph is 8 rows of 8 bits, and bit 7 of a row is its leftmost pixel.
- R9: Pixels with `in_de` low are never altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osd_on | input | 1 | 1 draws the text, 0 passes the video through |
| pos_cfg | input | 8 | Text origin: [7:4] row code, [3:0] column code |
| ctl_cfg | input | 6 | [5:4] size code, [3:0] palette index |
| char_codes | input | 28 | Seven 4-bit character codes, slot 0 in the low bits |
| char_cnt | input | 3 | Number of slots drawn |
| in_rgb | input | 24 | Input pixel {R,G,B} |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_de | input | 1 | Input data enable |
| out_rgb | output | 24 | Output pixel {R,G,B} |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_de | output | 1 | Delayed data enable |

## Verification
The bench sends whole frames of a position-dependent pixel ramp and changes the configuration between frames. Four frames cover all four size codes, each with a different origin, count and colour. Primary and grey colours show that the palette and the scaled glyph lookup are correct, and different origin codes expose any error in the offset arithmetic. A frame with the overlay disabled and a frame with a count of zero separate the enable path from the slot limit. Blanking carries a constant non-zero colour, so any change to a pixel outside active video is caught.

// File: rtl/text_osd_overlay.sv
module text_osd_overlay #(
  parameter int CW    = 12,
  parameter int NCHAR = 7,
  parameter int CNT_W = $clog2(NCHAR + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 osd_on,
  input  logic [7:0]           pos_cfg,
  input  logic [5:0]           ctl_cfg,
  input  logic [NCHAR*4-1:0]   char_codes,
  input  logic [CNT_W-1:0]     char_cnt,
  input  logic [23:0]          in_rgb,
  input  logic                 in_hs,
  input  logic                 in_vs,
  input  logic                 in_de,
  output logic [23:0]          out_rgb,
  output logic                 out_hs,
  output logic                 out_vs,
  output logic                 out_de
);

  localparam int SW = CW - 3;

  function automatic logic [63:0] font(input logic [3:0] c);
    case (c)
      4'd0:  return 64'h3C666E7666663C00;
      4'd1:  return 64'h1838181818187E00;
      4'd2:  return 64'h3C66060C30607E00;
      4'd3:  return 64'h3C66061C06663C00;
      4'd4:  return 64'h0C1C3C6C7E0C0C00;
      4'd5:  return 64'h7E607C0606663C00;
      4'd6:  return 64'h3C607C6666663C00;
      4'd7:  return 64'h7E060C1830303000;
      4'd8:  return 64'h3C66663C66663C00;
      4'd9:  return 64'h3C66663E060C3800;
      4'd10: return 64'h3C66606060663C00;
      4'd11: return 64'h6666667E66666600;
      4'd12: return 64'h66767E7E6E666600;
      4'd13: return 64'h3C66603C06663C00;
      4'd14: return 64'h0000007E00000000;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [23:0] palette(input logic [3:0] c);
    logic [7:0] g;
    case (c)
      4'd0: return 24'hFF0000;
      4'd1: return 24'h00FF00;
      4'd2: return 24'h0000FF;
      4'd3: return 24'hFFFF00;
      4'd4: return 24'hFF00FF;
      4'd5: return 24'h00FFFF;
      default: begin
        g = {c - 4'd5, 4'h0};
        return {g, g, g};
      end
    endcase
  endfunction

  function automatic logic [CW-1:0] shrink(input logic [CW-1:0] v, input logic [1:0] n);
    case (n)
      2'd0: return v;
      2'd1: return v >> 1;
      2'd2: return v / CW'(3);
      default: return v >> 2;
    endcase
  endfunction

  logic [3:0] codes [NCHAR];
  for (genvar k = 0; k < NCHAR; k++) begin : g_slot
    assign codes[k] = char_codes[4*k +: 4];
  end

  logic [CW-1:0] x_q, y_q;
  logic          de_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q  <= '0;
      y_q  <= '0;
      de_q <= 1'b0;
    end else begin
      de_q <= in_de;
      x_q  <= in_de ? x_q + 1'b1 : '0;
      if (in_vs)              y_q <= '0;
      else if (de_q && !in_de) y_q <= y_q + 1'b1;
    end
  end

  wire [CW-1:0] row0 = CW'({pos_cfg[7:4], 2'b00}) + CW'(8);
  wire [CW-1:0] col0 = CW'({pos_cfg[3:0], 2'b00}) + CW'(20);
  wire [CW-1:0] gx   = shrink(x_q - col0, ctl_cfg[5:4]);
  wire [CW-1:0] gy   = shrink(y_q - row0, ctl_cfg[5:4]);
  wire [SW-1:0] slot = gx[CW-1:3];
  wire [CNT_W-1:0] slot_i = slot[CNT_W-1:0];
  wire [3:0]    code = (32'(slot_i) < NCHAR) ? codes[slot_i] : 4'hF;
  wire [63:0]   gly  = font(code);
  wire [5:0]    bidx = 6'd63 - {gy[2:0], gx[2:0]};

  wire hit0 = osd_on && in_de && (x_q >= col0) && (y_q >= row0) &&
              (gy[CW-1:3] == '0) && (slot < SW'(char_cnt)) && gly[bidx];

  logic [23:0] rgb1;
  logic        hs1, vs1, de1, hit1;
  logic [3:0]  sel1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {rgb1, hs1, vs1, de1, hit1, sel1} <= '0;
      {out_rgb, out_hs, out_vs, out_de} <= '0;
    end else begin
      rgb1 <= in_rgb;
      hs1  <= in_hs;
      vs1  <= in_vs;
      de1  <= in_de;
      hit1 <= hit0;
      sel1 <= ctl_cfg[3:0];
      out_rgb <= hit1 ? palette(sel1) : rgb1;
      out_hs  <= hs1;
      out_vs  <= vs1;
      out_de  <= de1;
    end
  end

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 1'b1;
  end

  p_sync_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (out_hs == $past(in_hs, 2) && out_vs == $past(in_vs, 2) &&
                        out_de == $past(in_de, 2)));

  p_pass_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && !$past(osd_on, 2)) |-> (out_rgb == $past(in_rgb, 2)));

  p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && !out_de) |-> (out_rgb == $past(in_rgb, 2)));

  p_grey_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1 && sel1 >= 4'd6) |=> (out_rgb[23:16] == out_rgb[15:8] &&
                                out_rgb[15:8] == out_rgb[7:0] && out_rgb[7:0] != 8'h0));

  p_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |-> ($past(char_cnt) != '0));

endmodule

// File: tb/tb_text_osd_overlay.sv
module tb_text_osd_overlay;
  localparam int W = 200, LINES = 60, HBL = 8, VBL = 3;

  logic clk = 0, rst_n = 0;
  logic osd_on = 0;
  logic [7:0] pos_cfg = 0;
  logic [5:0] ctl_cfg = 0;
  logic [27:0] char_codes = 0;
  logic [2:0] char_cnt = 0;
  logic [23:0] in_rgb = 0;
  logic in_hs = 0, in_vs = 0, in_de = 0;
  logic [23:0] out_rgb;
  logic out_hs, out_vs, out_de;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string ftag;
  logic [26:0] exp_q [$];
  string tag_q [$];

  always #4 clk = ~clk;

  text_osd_overlay dut (.clk(clk), .rst_n(rst_n), .osd_on(osd_on), .pos_cfg(pos_cfg),
    .ctl_cfg(ctl_cfg), .char_codes(char_codes), .char_cnt(char_cnt), .in_rgb(in_rgb),
    .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de), .out_rgb(out_rgb), .out_hs(out_hs),
    .out_vs(out_vs), .out_de(out_de));

  function automatic logic [63:0] glyph(int c);
    logic [63:0] t [16] = '{64'h3C666E7666663C00, 64'h1838181818187E00, 64'h3C66060C30607E00,
      64'h3C66061C06663C00, 64'h0C1C3C6C7E0C0C00, 64'h7E607C0606663C00, 64'h3C607C6666663C00,
      64'h7E060C1830303000, 64'h3C66663C66663C00, 64'h3C66663E060C3800, 64'h3C66606060663C00,
      64'h6666667E66666600, 64'h66767E7E6E666600, 64'h3C66603C06663C00, 64'h0000007E00000000,
      64'h0};
    return t[c];
  endfunction

  function automatic logic [23:0] colour(int c);
    int g;
    if (c == 0) return 24'hFF0000;
    if (c == 1) return 24'h00FF00;
    if (c == 2) return 24'h0000FF;
    if (c == 3) return 24'hFFFF00;
    if (c == 4) return 24'hFF00FF;
    if (c == 5) return 24'h00FFFF;
    g = 16 * (c - 5);
    return {g[7:0], g[7:0], g[7:0]};
  endfunction

  function automatic bit is_text(int col, int row);
    int s, dx, dy, gx, gy, k, code;
    logic [63:0] f;
    if (!osd_on) return 0;
    s  = int'(ctl_cfg[5:4]) + 1;
    dx = col - (4 * int'(pos_cfg[3:0]) + 20);
    dy = row - (4 * int'(pos_cfg[7:4]) + 8);
    if (dx < 0 || dy < 0 || dy >= 8 * s || dx >= int'(char_cnt) * 8 * s) return 0;
    gx = dx / s; gy = dy / s; k = gx / 8;
    code = int'(char_codes[4*k +: 4]);
    f = glyph(code);
    return f[63 - 8 * gy - (gx % 8)];
  endfunction

  task automatic step(logic [23:0] rgb, logic hs, logic vs, logic de, int col, int row);
    logic [26:0] e;
    string t;
    bit txt;
    @(negedge clk);
    cyc++;
    if (exp_q.size() == 2) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (out_rgb !== e[26:3]) begin
        n_bad++;
        $display("FAIL %s: out_rgb=%h expected %h", t, out_rgb, e[26:3]);
      end
      n_chk++;
      if ({out_hs, out_vs, out_de} !== e[2:0]) begin
        n_bad++;
        $display("FAIL R6 timing: hs/vs/de=%b expected %b", {out_hs, out_vs, out_de}, e[2:0]);
      end
    end
    in_rgb = rgb; in_hs = hs; in_vs = vs; in_de = de;
    txt = de && is_text(col, row);
    exp_q.push_back({txt ? colour(int'(ctl_cfg[3:0])) : rgb, hs, vs, de});
    if (txt) t = "R3 R4 R8 text pixel";
    else if (!de) t = "R9 blanking";
    else t = ftag;
    tag_q.push_back(t);
  endtask

  task automatic frame(bit en, logic [7:0] p, logic [5:0] c, logic [2:0] n, string tg);
    osd_on = en; pos_cfg = p; ctl_cfg = c; char_cnt = n; ftag = tg;
    for (int v = 0; v < VBL; v++)
      for (int h = 0; h < W + HBL; h++)
        step(24'hA5C3E1, h < 4, v == 0, 1'b0, 0, 0);
    for (int r = 0; r < LINES; r++) begin
      for (int h = 0; h < HBL; h++) step(24'hA5C3E1, h < 4, 1'b0, 1'b0, 0, r);
      for (int x = 0; x < W; x++)
        step({x[7:0] ^ 8'h5A, r[7:0] + 8'd3, x[7:0] + r[7:0]}, 1'b0, 1'b0, 1'b1, x, r);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    n_chk++;
    if ({out_rgb, out_hs, out_vs, out_de} !== 27'h0) begin
      n_bad++;
      $display("FAIL R1 reset: outputs=%h expected 0", {out_rgb, out_hs, out_vs, out_de});
    end
    rst_n = 1;
    char_codes = {4'd13, 4'd14, 4'd11, 4'd12, 4'd10, 4'd2, 4'd1};
    frame(1, 8'h00, {2'd0, 4'd5}, 3'd3, "R2 R3 size0 cyan");
    char_codes = {4'd9, 4'd8, 4'd7, 4'd6, 4'd5, 4'd4, 4'd0};
    frame(1, 8'h21, {2'd1, 4'd6}, 3'd7, "R2 R3 size1 grey");
    char_codes = {4'd15, 4'd15, 4'd15, 4'd3, 4'd11, 4'd10, 4'd8};
    frame(1, 8'h10, {2'd3, 4'd15}, 3'd4, "R2 R3 size3 grey");
    char_codes = {4'd0, 4'd0, 4'd12, 4'd14, 4'd13, 4'd7, 4'd6};
    frame(1, 8'h32, {2'd2, 4'd0}, 3'd5, "R2 R3 size2 red");
    frame(0, 8'h00, {2'd0, 4'd1}, 3'd7, "R5 overlay off");
    frame(1, 8'h00, {2'd0, 4'd2}, 3'd0, "R7 zero count");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: cycles=%0d expected under 190000", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule